// File: doc/BRIEF.md
# Lane Alignment Sequence Checker

This block watches the octet stream of logical lane 0 of a multi-lane serial link once code-group synchronization is done. When the receiver releases its synchronization request, the checker waits for the first octet that is not a /K/ comma. That octet opens the initial alignment sequence. From there the checker counts frames and multiframes. It confirms that every multiframe closes with the /A/ alignment character and that no stray control character appears. It also reads the link configuration carried in the second multiframe and compares it with the values programmed locally.

Four flags are reported. `ilas_good` means the whole sequence had the expected structure. `ilas_bad` means the sequence broke; the checker then stays frozen until the next resynchronization. `cfg_mismatch` and `csum_good` report the result of the configuration comparison and of its modulo-256 checksum. A one-cycle `data_start` strobe marks the first user-data octet, which is also the octet where descrambling would begin.

Top module: `ilas_checker`

## Requirements
- R1: After reset, and in every cycle after a cycle with `sync_req` high, `ilas_good`, `ilas_bad`, `cfg_mismatch` and `csum_good` are 0, and the checker returns to waiting for the sequence start.
- R2: After `sync_req` falls, /K/ octets (`rx_is_k`=1, `rx_octet`=8'hBC) are ignored. The first valid octet that is not /K/ is octet 0 of multiframe 0.
- R3: A multiframe is F*K octets long. F is taken from `cfg_fpo` (value 1, 2 or 4; any other value acts as 4). K is 32 when F=1 and 16 otherwise, so a multiframe is 32, 32 or 64 octets.
- R4: The last octet of every multiframe must be /A/ (`rx_is_k`=1, 8'h7C). Otherwise `ilas_bad` rises in the cycle after that octet.
- R5: Multiframe 1 (the second one) must open with /R/ (k, 8'h1C) at octet 0 and /Q/ (k, 8'h9C) at octet 1. Outside multiframe ends, /R/ is accepted only at octet 0 of a multiframe and /Q/ only at octet 1 of multiframe 1. Any other control octet sets `ilas_bad`.
- R6: Once `ilas_bad` is set, further octets, including well-formed sequences, change no output until `sync_req` is raised.
- R7: The sequence lasts 4*`cfg_ilas_len` multiframes, and a length value of 0 counts as 1 (4 multiframes). `ilas_good` stays 0 before the last multiframe ends.
- R8: `ilas_good` rises in the cycle after the final /A/ of the last multiframe and holds until `sync_req`. It is never high together with `ilas_bad`.
- R9: `data_start` is high during exactly one valid octet, the first one presented after the final /A/. It is combinational on `rx_valid`.
- R10: Octets 2 to 15 of multiframe 1 are parameters p0..p13. `cfg_mismatch` is set in the cycle after p13 if any of the following fails:
  - p0 equals `cfg_dev_id`
  - p1 equals `cfg_bank_id` zero-extended
  - p2 equals `cfg_lane_id` zero-extended
  - p3 equals `cfg_lanes_m1` (lane count minus one) zero-extended

  Reserved upper bits of p1..p3 must therefore be zero.
- R11: `csum_good` is set in the cycle after p13 when p13 equals the sum of p0..p12 modulo 256.
- R12: A cycle with `rx_valid` low is ignored: no counter advances and no flag changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Octet clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sync_req | input | 1 | Synchronization request from the link layer; high restarts the checker |
| rx_valid | input | 1 | Octet on `rx_octet` is valid this cycle |
| rx_is_k | input | 1 | Octet is a control character |
| rx_octet | input | 8 | Decoded lane-0 octet |
| cfg_fpo | input | 3 | Octets per frame (1, 2 or 4) |
| cfg_ilas_len | input | LEN_W (2) | Sequence length in units of four multiframes |
| cfg_dev_id | input | 8 | Expected device identifier |
| cfg_bank_id | input | BID_W (4) | Expected bank identifier |
| cfg_lane_id | input | LID_W (5) | Expected identifier of lane 0 |
| cfg_lanes_m1 | input | LCNT_W (5) | Expected lane count minus one |
| ilas_good | output | 1 | Sequence completed with correct structure |
| ilas_bad | output | 1 | Sequence structure error; held until resync |
| cfg_mismatch | output | 1 | Received configuration differs from local values |
| csum_good | output | 1 | Received checksum matches the parameter sum |
| data_start | output | 1 | Strobe on the first user-data octet |

## Verification
The bench builds the checker with its default parameters: K of 32 and 16, and a two-bit length field. At run time it drives all three frame sizes, giving multiframes of 32 and 64 octets, and length codes of 0, 1 and 2, giving sequences of 4 and 8 multiframes. These settings cover the longest counter wrap, the length-zero rule and the check that nothing completes early. Input gaps, wrong identifiers, non-zero reserved bits, a corrupt checksum, a missing /A/ and a stray control octet are each applied against a behavioural model that is compared on every cycle.

// File: rtl/ilas_chk_pkg.sv
package ilas_chk_pkg;
    localparam logic [7:0] K_SYNC  = 8'hBC;
    localparam logic [7:0] K_ALIGN = 8'h7C;
    localparam logic [7:0] K_START = 8'h1C;
    localparam logic [7:0] K_CFG   = 8'h9C;

    localparam int CFG_FIRST  = 2;
    localparam int CFG_OCTETS = 14;

    typedef enum logic [2:0] {
        ST_HUNT,
        ST_ILAS,
        ST_ARM,
        ST_DATA,
        ST_FAIL
    } ctl_state_e;
endpackage

// File: rtl/ilas_mf_counter.sv
module ilas_mf_counter #(
    parameter int OCT_W = 6,
    parameter int MF_W  = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             adv,
    input  logic [OCT_W:0]   mf_len,
    output logic [OCT_W-1:0] oct_idx,
    output logic [MF_W-1:0]  mf_idx,
    output logic             mf_last
);
    localparam logic [OCT_W:0] LEN_ONE = 1;

    typedef struct packed {
        logic [OCT_W-1:0] oct;
        logic [MF_W-1:0]  mf;
    } pos_t;

    pos_t pos_d, pos_q;

    always_comb begin
        mf_last = ({1'b0, pos_q.oct} == (mf_len - LEN_ONE));
        pos_d   = pos_q;
        if (clr) begin
            pos_d = '0;
        end else if (adv) begin
            if (mf_last) begin
                pos_d.oct = '0;
                pos_d.mf  = pos_q.mf + 1'b1;
            end else begin
                pos_d.oct = pos_q.oct + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pos_q <= '0;
        else        pos_q <= pos_d;
    end

    assign oct_idx = pos_q.oct;
    assign mf_idx  = pos_q.mf;
endmodule

// File: rtl/ilas_cfg_check.sv
module ilas_cfg_check
    import ilas_chk_pkg::*;
#(
    parameter int OCT_W  = 6,
    parameter int MF_W   = 4,
    parameter int BID_W  = 4,
    parameter int LID_W  = 5,
    parameter int LCNT_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              adv,
    input  logic [OCT_W-1:0]  oct_idx,
    input  logic [MF_W-1:0]   mf_idx,
    input  logic [7:0]        rx_octet,
    input  logic [7:0]        cfg_dev_id,
    input  logic [BID_W-1:0]  cfg_bank_id,
    input  logic [LID_W-1:0]  cfg_lane_id,
    input  logic [LCNT_W-1:0] cfg_lanes_m1,
    output logic              cfg_mismatch,
    output logic              csum_good
);
    localparam logic [OCT_W-1:0] P_LO   = OCT_W'(CFG_FIRST);
    localparam logic [OCT_W-1:0] P_HI   = OCT_W'(CFG_FIRST + CFG_OCTETS);
    localparam logic [OCT_W-1:0] P_CSUM = OCT_W'(CFG_OCTETS - 1);

    typedef struct packed {
        logic [7:0] sum;
        logic       miss;
        logic       mism;
        logic       csok;
    } cfg_t;

    cfg_t             cfg_d, cfg_q;
    logic             in_cfg;
    logic [OCT_W-1:0] p_idx;
    logic [7:0]       want;
    logic             check_it;

    always_comb begin
        in_cfg   = adv && (mf_idx == MF_W'(1)) && (oct_idx >= P_LO) && (oct_idx < P_HI);
        p_idx    = oct_idx - P_LO;
        want     = rx_octet;
        check_it = 1'b1;
        if (p_idx == OCT_W'(0))      want = cfg_dev_id;
        else if (p_idx == OCT_W'(1)) want = 8'(cfg_bank_id);
        else if (p_idx == OCT_W'(2)) want = 8'(cfg_lane_id);
        else if (p_idx == OCT_W'(3)) want = 8'(cfg_lanes_m1);
        else                         check_it = 1'b0;

        cfg_d = cfg_q;
        if (clr) begin
            cfg_d = '0;
        end else if (in_cfg) begin
            if (p_idx == P_CSUM) begin
                cfg_d.mism = cfg_q.miss;
                cfg_d.csok = (cfg_q.sum == rx_octet);
            end else begin
                cfg_d.sum = cfg_q.sum + rx_octet;
                if (check_it && (want != rx_octet)) cfg_d.miss = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign cfg_mismatch = cfg_q.mism;
    assign csum_good    = cfg_q.csok;
endmodule

// File: rtl/ilas_checker.sv
module ilas_checker
    import ilas_chk_pkg::*;
#(
    parameter int K_F1    = 32,
    parameter int K_OTHER = 16,
    parameter int LEN_W   = 2,
    parameter int BID_W   = 4,
    parameter int LID_W   = 5,
    parameter int LCNT_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sync_req,
    input  logic              rx_valid,
    input  logic              rx_is_k,
    input  logic [7:0]        rx_octet,
    input  logic [2:0]        cfg_fpo,
    input  logic [LEN_W-1:0]  cfg_ilas_len,
    input  logic [7:0]        cfg_dev_id,
    input  logic [BID_W-1:0]  cfg_bank_id,
    input  logic [LID_W-1:0]  cfg_lane_id,
    input  logic [LCNT_W-1:0] cfg_lanes_m1,
    output logic              ilas_good,
    output logic              ilas_bad,
    output logic              cfg_mismatch,
    output logic              csum_good,
    output logic              data_start
);
    localparam int MF_OCT_F1 = K_F1;
    localparam int MF_OCT_F2 = 2 * K_OTHER;
    localparam int MF_OCT_F4 = 4 * K_OTHER;
    localparam int MAX_MF_OCT = (MF_OCT_F1 > MF_OCT_F4) ? MF_OCT_F1 : MF_OCT_F4;
    localparam int OCT_W = $clog2(MAX_MF_OCT);
    localparam int MF_W  = LEN_W + 2;
    localparam logic [MF_W-1:0] MF_ONE = 1;

    typedef struct packed {
        ctl_state_e st;
        logic       good;
    } ctl_t;

    ctl_t             ctl_d, ctl_q;
    logic [OCT_W-1:0] oct_idx;
    logic [MF_W-1:0]  mf_idx;
    logic             mf_last;
    logic [OCT_W:0]   mf_len;
    logic [LEN_W-1:0] len_eff;
    logic [MF_W-1:0]  mf_total;
    logic             is_sync_k, in_seq, last_mf, err;

    always_comb begin
        case (cfg_fpo)
            3'd1:    mf_len = (OCT_W+1)'(MF_OCT_F1);
            3'd2:    mf_len = (OCT_W+1)'(MF_OCT_F2);
            default: mf_len = (OCT_W+1)'(MF_OCT_F4);
        endcase
        len_eff   = (cfg_ilas_len == '0) ? LEN_W'(1) : cfg_ilas_len;
        mf_total  = {len_eff, 2'b00};
        last_mf   = (mf_idx == (mf_total - MF_ONE));
        is_sync_k = rx_is_k && (rx_octet == K_SYNC);
        in_seq    = !sync_req && rx_valid &&
                    (((ctl_q.st == ST_HUNT) && !is_sync_k) || (ctl_q.st == ST_ILAS));

        if (mf_last)
            err = !(rx_is_k && (rx_octet == K_ALIGN));
        else if ((mf_idx == MF_ONE) && (oct_idx == '0))
            err = !(rx_is_k && (rx_octet == K_START));
        else if ((mf_idx == MF_ONE) && (oct_idx == OCT_W'(1)))
            err = !(rx_is_k && (rx_octet == K_CFG));
        else if (rx_is_k)
            err = !((oct_idx == '0) && (rx_octet == K_START));
        else
            err = 1'b0;

        ctl_d = ctl_q;
        if (sync_req) begin
            ctl_d.st   = ST_HUNT;
            ctl_d.good = 1'b0;
        end else begin
            case (ctl_q.st)
                ST_HUNT, ST_ILAS: begin
                    if (in_seq) begin
                        if (err) begin
                            ctl_d.st = ST_FAIL;
                        end else if (mf_last && last_mf) begin
                            ctl_d.st   = ST_ARM;
                            ctl_d.good = 1'b1;
                        end else begin
                            ctl_d.st = ST_ILAS;
                        end
                    end
                end
                ST_ARM:  if (rx_valid) ctl_d.st = ST_DATA;
                default: ctl_d = ctl_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '{st: ST_HUNT, good: 1'b0};
        else        ctl_q <= ctl_d;
    end

    ilas_mf_counter #(.OCT_W(OCT_W), .MF_W(MF_W)) u_pos (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (sync_req),
        .adv     (in_seq),
        .mf_len  (mf_len),
        .oct_idx (oct_idx),
        .mf_idx  (mf_idx),
        .mf_last (mf_last)
    );

    ilas_cfg_check #(
        .OCT_W (OCT_W), .MF_W (MF_W), .BID_W (BID_W), .LID_W (LID_W), .LCNT_W (LCNT_W)
    ) u_cfg (
        .clk          (clk),
        .rst_n        (rst_n),
        .clr          (sync_req),
        .adv          (in_seq),
        .oct_idx      (oct_idx),
        .mf_idx       (mf_idx),
        .rx_octet     (rx_octet),
        .cfg_dev_id   (cfg_dev_id),
        .cfg_bank_id  (cfg_bank_id),
        .cfg_lane_id  (cfg_lane_id),
        .cfg_lanes_m1 (cfg_lanes_m1),
        .cfg_mismatch (cfg_mismatch),
        .csum_good    (csum_good)
    );

    assign ilas_good  = ctl_q.good;
    assign ilas_bad   = (ctl_q.st == ST_FAIL);
    assign data_start = (ctl_q.st == ST_ARM) && rx_valid && !sync_req;
endmodule

// File: rtl/ilas_checker_sva.sv
module ilas_checker_sva (
    input logic clk,
    input logic rst_n,
    input logic sync_req,
    input logic rx_valid,
    input logic ilas_good,
    input logic ilas_bad,
    input logic cfg_mismatch,
    input logic csum_good,
    input logic data_start
);
    a_r1_sync_clears: assert property (@(posedge clk) disable iff (!rst_n)
        sync_req |=> (!ilas_good && !ilas_bad && !cfg_mismatch && !csum_good));

    a_r6_bad_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (ilas_bad && !sync_req) |=> ilas_bad);

    a_r8_good_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (ilas_good && !sync_req) |=> ilas_good);

    a_r8_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(ilas_good && ilas_bad));

    a_r9_start_needs_good: assert property (@(posedge clk) disable iff (!rst_n)
        data_start |-> (ilas_good && rx_valid));

    a_r9_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        data_start |=> !data_start);

    a_r12_idle_no_change: assert property (@(posedge clk) disable iff (!rst_n)
        (!rx_valid && !sync_req) |=> ($stable(ilas_good) && $stable(ilas_bad)
                                      && $stable(cfg_mismatch) && $stable(csum_good)));
endmodule

bind ilas_checker ilas_checker_sva u_sva (
    .clk          (clk),
    .rst_n        (rst_n),
    .sync_req     (sync_req),
    .rx_valid     (rx_valid),
    .ilas_good    (ilas_good),
    .ilas_bad     (ilas_bad),
    .cfg_mismatch (cfg_mismatch),
    .csum_good    (csum_good),
    .data_start   (data_start)
);

// File: tb/tb_ilas_checker.sv
`timescale 1ns/1ps
module tb_ilas_checker;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sync_req = 1'b0;
    logic       rx_valid = 1'b0;
    logic       rx_is_k = 1'b0;
    logic [7:0] rx_octet = 8'h00;
    logic [2:0] cfg_fpo = 3'd1;
    logic [1:0] cfg_ilas_len = 2'd1;
    logic [7:0] cfg_dev_id = 8'h5A;
    logic [3:0] cfg_bank_id = 4'h3;
    logic [4:0] cfg_lane_id = 5'd2;
    logic [4:0] cfg_lanes_m1 = 5'd3;
    logic ilas_good, ilas_bad, cfg_mismatch, csum_good, data_start;

    int vectors = 0;
    int miscompares = 0;
    int ds_count = 0;
    bit finished = 0;
    logic [8:0] seq[$];

    // behavioural reference state
    int m_st = 0;   // 0 hunt, 1 ilas, 2 arm, 3 data, 4 fail
    int m_oct = 0, m_mf = 0, m_sum = 0;
    bit m_miss = 0, m_good = 0, m_mism = 0, m_csok = 0;

    always #4 clk = ~clk;

    ilas_checker dut (
        .clk(clk), .rst_n(rst_n), .sync_req(sync_req), .rx_valid(rx_valid),
        .rx_is_k(rx_is_k), .rx_octet(rx_octet), .cfg_fpo(cfg_fpo),
        .cfg_ilas_len(cfg_ilas_len), .cfg_dev_id(cfg_dev_id), .cfg_bank_id(cfg_bank_id),
        .cfg_lane_id(cfg_lane_id), .cfg_lanes_m1(cfg_lanes_m1),
        .ilas_good(ilas_good), .ilas_bad(ilas_bad), .cfg_mismatch(cfg_mismatch),
        .csum_good(csum_good), .data_start(data_start)
    );

    always @(posedge clk) begin
        if (!rst_n || sync_req) begin
            m_st = 0; m_oct = 0; m_mf = 0; m_sum = 0;
            m_miss = 0; m_good = 0; m_mism = 0; m_csok = 0;
        end else if (rx_valid) begin
            if (m_st == 2) begin
                m_st = 3;
            end else if ((m_st == 0 && !(rx_is_k && rx_octet == 8'hBC)) || m_st == 1) begin
                int flen, ntot, p;
                bit last, e;
                flen = (cfg_fpo == 1 || cfg_fpo == 2) ? 32 : 64;
                ntot = 4 * ((cfg_ilas_len == 0) ? 1 : cfg_ilas_len);
                last = (m_oct == flen - 1);
                if (last) e = !(rx_is_k && rx_octet == 8'h7C);
                else if (m_mf == 1 && m_oct == 0) e = !(rx_is_k && rx_octet == 8'h1C);
                else if (m_mf == 1 && m_oct == 1) e = !(rx_is_k && rx_octet == 8'h9C);
                else if (rx_is_k) e = !(m_oct == 0 && rx_octet == 8'h1C);
                else e = 0;
                if (m_mf == 1 && m_oct >= 2 && m_oct < 16) begin
                    p = m_oct - 2;
                    if (p == 13) begin
                        m_mism = m_miss;
                        m_csok = (m_sum == int'(rx_octet));
                    end else begin
                        m_sum = (m_sum + int'(rx_octet)) % 256;
                        if (p == 0 && rx_octet != cfg_dev_id) m_miss = 1;
                        if (p == 1 && rx_octet != {4'h0, cfg_bank_id}) m_miss = 1;
                        if (p == 2 && rx_octet != {3'h0, cfg_lane_id}) m_miss = 1;
                        if (p == 3 && rx_octet != {3'h0, cfg_lanes_m1}) m_miss = 1;
                    end
                end
                if (e) m_st = 4;
                else if (last && m_mf == ntot - 1) begin m_st = 2; m_good = 1; end
                else m_st = 1;
                if (last) begin m_oct = 0; m_mf = m_mf + 1; end
                else m_oct = m_oct + 1;
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        vectors++;
        if (!ok) begin
            miscompares++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic compare();
        bit e_ds;
        e_ds = (m_st == 2) && rx_valid && !sync_req && rst_n;
        if (data_start) ds_count++;
        chk(data_start == e_ds, "R9 data_start", data_start, e_ds);
        chk(ilas_good == m_good, "R8 ilas_good", ilas_good, m_good);
        chk(ilas_bad == (m_st == 4), "R4 ilas_bad", ilas_bad, m_st == 4);
        chk(cfg_mismatch == m_mism, "R10 cfg_mismatch", cfg_mismatch, m_mism);
        chk(csum_good == m_csok, "R11 csum_good", csum_good, m_csok);
    endtask

    task automatic step(input bit v, input bit k, input logic [7:0] o);
        @(negedge clk);
        rx_valid = v; rx_is_k = k; rx_octet = o;
        #1 compare();
    endtask

    task automatic resync();
        sync_req = 1'b1;
        repeat (3) step(1'b1, 1'b1, 8'hBC);
        sync_req = 1'b0;
        repeat (6) step(1'b1, 1'b1, 8'hBC);
        ds_count = 0;
    endtask

    task automatic gen(input int flen, input int nmf, input logic [7:0] did,
                       input logic [7:0] bid, input logic [7:0] lid, input logic [7:0] lcm,
                       input int csum_off, input int drop_mf, input int badk_mf);
        logic [7:0] p[14];
        int s;
        seq.delete();
        p[0] = did; p[1] = bid; p[2] = lid; p[3] = lcm;
        for (int i = 4; i < 13; i++) p[i] = 8'(i * 17 + 3);
        s = 0;
        for (int i = 0; i < 13; i++) s = s + int'(p[i]);
        p[13] = 8'(s + csum_off);
        for (int m = 0; m < nmf; m++) begin
            for (int o = 0; o < flen; o++) begin
                if (o == flen - 1) seq.push_back((m == drop_mf) ? 9'h055 : 9'h17C);
                else if (o == 0) seq.push_back(9'h11C);
                else if (m == 1 && o == 1) seq.push_back(9'h19C);
                else if (m == 1 && o >= 2 && o < 16) seq.push_back({1'b0, p[o-2]});
                else if (m == badk_mf && o == 5) seq.push_back(9'h1FC);
                else seq.push_back({1'b0, 8'(m * 7 + o)});
            end
        end
    endtask

    task automatic play(input bit gaps, input int chk_at);
        for (int i = 0; i < seq.size(); i++) begin
            if (i == chk_at) chk(ilas_good == 1'b0, "R7 early completion", ilas_good, 0);
            if (gaps && (i % 5 == 3)) step(1'b0, 1'b1, 8'h7C);
            step(1'b1, seq[i][8], seq[i][7:0]);
        end
        for (int i = 0; i < 4; i++) step(1'b1, 1'b0, 8'(8'hA0 + i));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            miscompares++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        repeat (3) step(1'b0, 1'b0, 8'h00);
        chk({ilas_good, ilas_bad, cfg_mismatch, csum_good, data_start} == 5'b0,
            "R1 reset state", {ilas_good, ilas_bad, cfg_mismatch, csum_good}, 0);
        rst_n = 1'b1;

        // A: F=1, 4 multiframes, matching configuration; leading /K/ ignored (R2)
        cfg_fpo = 3'd1; cfg_ilas_len = 2'd1;
        resync();
        gen(32, 4, 8'h5A, 8'h03, 8'h02, 8'h03, 0, -1, -1);
        play(1'b0, -1);
        chk(ilas_good, "R2 start after /K/ run", ilas_good, 1);
        chk(csum_good, "R11 checksum accepted", csum_good, 1);
        chk(!cfg_mismatch, "R10 config match", cfg_mismatch, 0);
        chk(ds_count == 1, "R9 single data strobe", ds_count, 1);

        // B: F=4, 8 multiframes of 64 octets, with idle gaps
        cfg_fpo = 3'd4; cfg_ilas_len = 2'd2;
        resync();
        gen(64, 8, 8'h5A, 8'h03, 8'h02, 8'h03, 0, -1, -1);
        play(1'b1, 4 * 64 + 4 * 64 / 5);
        chk(ilas_good, "R3 64-octet multiframes", ilas_good, 1);
        chk(ilas_good && ds_count == 1, "R12 gaps ignored", ds_count, 1);

        // C: F=2, wrong device identifier
        cfg_fpo = 3'd2; cfg_ilas_len = 2'd1;
        resync();
        gen(32, 4, 8'h5B, 8'h03, 8'h02, 8'h03, 0, -1, -1);
        play(1'b0, -1);
        chk(cfg_mismatch, "R10 device id mismatch", cfg_mismatch, 1);
        chk(ilas_good, "R3 F=2 multiframe length", ilas_good, 1);

        // D: corrupt checksum
        resync();
        gen(32, 4, 8'h5A, 8'h03, 8'h02, 8'h03, 1, -1, -1);
        play(1'b0, -1);
        chk(!csum_good, "R11 bad checksum", csum_good, 0);

        // E: reserved bit set in bank octet
        resync();
        gen(32, 4, 8'h5A, 8'h13, 8'h02, 8'h03, 0, -1, -1);
        play(1'b0, -1);
        chk(cfg_mismatch, "R10 reserved bits nonzero", cfg_mismatch, 1);

        // F: missing /A/ at multiframe 2, then a clean sequence without resync
        resync();
        gen(32, 4, 8'h5A, 8'h03, 8'h02, 8'h03, 0, 2, -1);
        play(1'b0, -1);
        chk(ilas_bad, "R4 missing /A/", ilas_bad, 1);
        gen(32, 4, 8'h5A, 8'h03, 8'h02, 8'h03, 0, -1, -1);
        play(1'b0, -1);
        chk(ilas_bad && !ilas_good && ds_count == 0, "R6 held after error", ilas_good, 0);

        // G: resync clears, then an unexpected control octet
        sync_req = 1'b1;
        step(1'b1, 1'b1, 8'hBC);
        step(1'b1, 1'b1, 8'hBC);
        chk(!ilas_bad && !ilas_good && !cfg_mismatch && !csum_good,
            "R1 sync clears flags", ilas_bad, 0);
        resync();
        gen(32, 4, 8'h5A, 8'h03, 8'h02, 8'h03, 0, -1, 0);
        play(1'b0, -1);
        chk(ilas_bad, "R5 stray control octet", ilas_bad, 1);

        // H: length code 0 counts as 4 multiframes
        cfg_fpo = 3'd1; cfg_ilas_len = 2'd0;
        resync();
        gen(32, 4, 8'h5A, 8'h03, 8'h02, 8'h03, 0, -1, -1);
        play(1'b0, -1);
        chk(ilas_good, "R7 length zero as four", ilas_good, 1);

        finished = 1;
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule